// File: doc/BRIEF.md
# Contiguous Command Slot Allocator

The block hands out runs of command slots inside a group of command sets. Each set holds a runtime-programmable number of slots, and the group has a programmable number of sets. One occupancy bitmap tracks which slots are taken. A client asks for a number of consecutive commands. The allocator returns the set and the first command position of the lowest free run that fits completely inside one set, and marks that run as taken.

If a request cannot be placed, the allocator returns a no-room code. If the count is zero or does not fit in one set, it returns a bad-count code. An invalidate input empties the whole bitmap in one cycle, which returns every slot to the pool.

The search goes one set per clock cycle. Each cycle, a parallel fit test runs over every start position in the current set and a priority pick takes the lowest position that fits. The full bitmap is driven out on a port so the client can see the current allocation.

Top module: `cmdslot_alloc`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `slot_map` is all zeros.
- R2: A successful allocation returns the lowest start slot S for which the whole run is free and lies inside one set. The reported set is S / `cfg_per_set` + `cfg_base`, the reported command is S mod `cfg_per_set`, and command + count never exceeds `cfg_per_set`.
- R3: When the lowest free run would cross the end of a set, it is skipped and the search continues at the first slot of the next set.
- R4: On success, the `count` slots starting at global slot set_local × `cfg_per_set` + command are set in `slot_map`, and no other bit changes. Bits are cleared only by invalidate.
- R5: If no set holds a free run of the requested length, `done_status` is 1 (no room) and `slot_map` is unchanged.
- R6: A count of 0, or a count larger than `cfg_per_set`, gives `done_status` 2 (bad count) and leaves `slot_map` unchanged. Success is `done_status` 0.
- R7: `inval` clears all of `slot_map` at the next clock edge. If it coincides with the commit of an allocation, the map still ends up all zeros.
- R8: A request is accepted on an edge where `req_valid` and `req_ready` are both high. `done` is a one-cycle pulse that comes s+1 cycles after acceptance when the run lands in local set s, `cfg_sets` cycles after acceptance for no room, and 1 cycle after acceptance for a bad count. While the block is busy, `req_ready` is 0 and `req_valid` is ignored.
- R9: `cfg_per_set` (1 to MAX_CPS) and `cfg_sets` (1 to MAX_SETS) may be changed while the block is idle. Slot numbering follows the values in force at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_per_set | input | CNT_W (5) | Command slots per set |
| cfg_sets | input | SETS_W (4) | Number of sets in the group |
| cfg_base | input | SET_W (3) | Set offset added to the reported set |
| inval | input | 1 | Clear the whole occupancy bitmap |
| req_valid | input | 1 | Allocation request |
| req_count | input | CNT_W (5) | Number of consecutive commands wanted |
| req_ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle result pulse |
| done_status | output | 2 | 0 ok, 1 no room, 2 bad count |
| done_set | output | SET_W+1 (4) | Allocated set index including base |
| done_cmd | output | CMD_W (4) | First command slot in the set |
| slot_map | output | TOTAL (128) | Occupancy bitmap, bit i is global slot i |

## Verification
Directed requests on a small group separate three cases: a run that fits at the start of a set, a lowest free run that crosses a set boundary and must move to the next set, and a single slot that fills the leftover gap below a boundary. Zero and oversized counts are tried against every tested geometry so the bad-count path is kept apart from the no-room path. The no-room path is reached by filling every set to capacity. Random request sizes under several per-set and set-count settings, with occasional invalidates, compare the returned positions, the exact latency and the full bitmap against an origin-restart search model. An invalidate placed on the commit edge shows that clearing wins.

// File: rtl/sa_pkg.sv
package sa_pkg;
   typedef enum logic [1:0] {
      SA_OK     = 2'd0,
      SA_NOROOM = 2'd1,
      SA_BADCNT = 2'd2
   } sa_status_e;

   typedef enum logic {
      SA_IDLE = 1'b0,
      SA_SCAN = 1'b1
   } sa_state_e;
endpackage

// File: rtl/sa_set_window.sv
module sa_set_window #(
   parameter int TOTAL   = 128,
   parameter int MAX_CPS = 16,
   parameter int IDX_W   = 7
) (
   input  logic [TOTAL-1:0]   occ,
   input  logic [IDX_W-1:0]   base,
   output logic [MAX_CPS-1:0] win
);
   logic [TOTAL-1:0] shifted;

   assign shifted = occ >> base;
   assign win     = shifted[MAX_CPS-1:0];
endmodule

// File: rtl/sa_fit_finder.sv
module sa_fit_finder #(
   parameter int MAX_CPS = 16,
   parameter int CNT_W   = 5,
   parameter int CMD_W   = 4
) (
   input  logic [MAX_CPS-1:0] win,
   input  logic [CNT_W-1:0]   cnt,
   input  logic [CNT_W-1:0]   per_set,
   output logic               hit,
   output logic [CMD_W-1:0]   off
);
   logic [MAX_CPS-1:0] need;
   logic [MAX_CPS-1:0] fit;

   always_comb begin
      for (int i = 0; i < MAX_CPS; i++) need[i] = (i < int'(cnt));
   end

   for (genvar c = 0; c < MAX_CPS; c++) begin : g_pos
      logic [MAX_CPS-1:0] seg;
      assign seg    = win >> c;
      assign fit[c] = ((c + int'(cnt)) <= int'(per_set)) && ((seg & need) == '0);
   end

   always_comb begin
      hit = |fit;
      off = '0;
      for (int i = MAX_CPS - 1; i >= 0; i--) begin
         if (fit[i]) off = CMD_W'(i);
      end
   end
endmodule

// File: rtl/sa_occ_reg.sv
module sa_occ_reg #(
   parameter int TOTAL = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             set_en,
   input  logic [TOTAL-1:0] set_mask,
   output logic [TOTAL-1:0] occ
);
   always_ff @(posedge clk) begin
      if (!rst_n)      occ <= '0;
      else if (clr)    occ <= '0;
      else if (set_en) occ <= occ | set_mask;
   end
endmodule

// File: rtl/cmdslot_alloc.sv
module cmdslot_alloc #(
   parameter int MAX_SETS = 8,
   parameter int MAX_CPS  = 16,
   localparam int TOTAL   = MAX_SETS * MAX_CPS,
   localparam int IDX_W   = $clog2(TOTAL),
   localparam int CNT_W   = $clog2(MAX_CPS + 1),
   localparam int CMD_W   = $clog2(MAX_CPS),
   localparam int SET_W   = (MAX_SETS > 1) ? $clog2(MAX_SETS) : 1,
   localparam int SETS_W  = $clog2(MAX_SETS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cfg_per_set,
   input  logic [SETS_W-1:0] cfg_sets,
   input  logic [SET_W-1:0]  cfg_base,
   input  logic              inval,
   input  logic              req_valid,
   input  logic [CNT_W-1:0]  req_count,
   output logic              req_ready,
   output logic              done,
   output logic [1:0]        done_status,
   output logic [SET_W:0]    done_set,
   output logic [CMD_W-1:0]  done_cmd,
   output logic [TOTAL-1:0]  slot_map
);
   import sa_pkg::*;

   if (MAX_SETS < 1) begin : g_bad_sets
      $error("MAX_SETS must be at least 1");
   end
   if (MAX_CPS < 2) begin : g_bad_cps
      $error("MAX_CPS must be at least 2");
   end

   sa_state_e         state_q;
   logic [SETS_W-1:0] cur_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              done_q;
   sa_status_e        status_q;
   logic [SET_W:0]    set_q;
   logic [CMD_W-1:0]  cmd_q;

   logic [IDX_W-1:0]   base;
   logic [MAX_CPS-1:0] win;
   logic               hit;
   logic [CMD_W-1:0]   off;
   logic               bad_cnt;
   logic               past_end;
   logic               last_set;
   logic               commit;
   logic [TOTAL-1:0]   run_lo;
   logic [TOTAL-1:0]   mark;

   assign base     = IDX_W'(cur_q) * IDX_W'(cfg_per_set);
   assign bad_cnt  = (cnt_q == '0) || (cnt_q > cfg_per_set);
   assign past_end = (cur_q >= cfg_sets);
   assign last_set = (SETS_W'(cur_q + 1'b1) >= cfg_sets);
   assign commit   = (state_q == SA_SCAN) && !bad_cnt && !past_end && hit;

   sa_set_window #(.TOTAL(TOTAL), .MAX_CPS(MAX_CPS), .IDX_W(IDX_W)) u_win (
      .occ  (slot_map),
      .base (base),
      .win  (win)
   );

   sa_fit_finder #(.MAX_CPS(MAX_CPS), .CNT_W(CNT_W), .CMD_W(CMD_W)) u_fit (
      .win     (win),
      .cnt     (cnt_q),
      .per_set (cfg_per_set),
      .hit     (hit),
      .off     (off)
   );

   always_comb begin
      run_lo = '0;
      for (int i = 0; i < MAX_CPS; i++) run_lo[i] = (i < int'(cnt_q));
      mark = run_lo << (base + IDX_W'(off));
   end

   sa_occ_reg #(.TOTAL(TOTAL)) u_occ (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (inval),
      .set_en   (commit),
      .set_mask (mark),
      .occ      (slot_map)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SA_IDLE;
         cur_q    <= '0;
         cnt_q    <= '0;
         done_q   <= 1'b0;
         status_q <= SA_OK;
         set_q    <= '0;
         cmd_q    <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            SA_IDLE: begin
               if (req_valid) begin
                  cnt_q   <= req_count;
                  cur_q   <= '0;
                  state_q <= SA_SCAN;
               end
            end
            SA_SCAN: begin
               if (bad_cnt) begin
                  status_q <= SA_BADCNT;
                  done_q   <= 1'b1;
                  state_q  <= SA_IDLE;
               end else if (past_end) begin
                  status_q <= SA_NOROOM;
                  done_q   <= 1'b1;
                  state_q  <= SA_IDLE;
               end else if (hit) begin
                  status_q <= SA_OK;
                  set_q    <= (SET_W + 1)'(cur_q) + (SET_W + 1)'(cfg_base);
                  cmd_q    <= off;
                  done_q   <= 1'b1;
                  state_q  <= SA_IDLE;
               end else if (last_set) begin
                  status_q <= SA_NOROOM;
                  done_q   <= 1'b1;
                  state_q  <= SA_IDLE;
               end else begin
                  cur_q <= cur_q + 1'b1;
               end
            end
            default: state_q <= SA_IDLE;
         endcase
      end
   end

   assign req_ready   = (state_q == SA_IDLE);
   assign done        = done_q;
   assign done_status = status_q;
   assign done_set    = set_q;
   assign done_cmd    = cmd_q;
endmodule

// File: rtl/cmdslot_alloc_chk.sv
module cmdslot_alloc_chk #(
   parameter int MAX_SETS = 8,
   parameter int MAX_CPS  = 16,
   localparam int TOTAL   = MAX_SETS * MAX_CPS,
   localparam int CNT_W   = $clog2(MAX_CPS + 1),
   localparam int CMD_W   = $clog2(MAX_CPS),
   localparam int SETS_W  = $clog2(MAX_SETS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CNT_W-1:0]  cfg_per_set,
   input logic [SETS_W-1:0] cfg_sets,
   input logic              inval,
   input logic              req_valid,
   input logic [CNT_W-1:0]  req_count,
   input logic              req_ready,
   input logic              done,
   input logic [1:0]        done_status,
   input logic [CMD_W-1:0]  done_cmd,
   input logic [TOTAL-1:0]  slot_map
);
   logic [CNT_W-1:0] cnt_cap;
   logic [7:0]       lat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_cap <= '0;
         lat     <= '0;
      end else if (req_valid && req_ready) begin
         cnt_cap <= req_count;
         lat     <= '0;
      end else if (!req_ready && lat != 8'hFF) begin
         lat <= lat + 8'd1;
      end
   end

   a_r2_run_in_set: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_status == 2'd0) |-> (int'(done_cmd) + int'(cnt_cap) <= int'(cfg_per_set)));

   a_r4_adds_count: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_status == 2'd0 && !$past(inval))
      |-> ($countones(slot_map) == $countones($past(slot_map)) + int'(cnt_cap)));

   a_r4_only_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(inval) |-> (($past(slot_map) & ~slot_map) == '0));

   // R5 and R6: a failed request leaves the map alone
   a_r5_fail_keeps_map: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_status != 2'd0 && !$past(inval)) |-> (slot_map == $past(slot_map)));

   a_r6_badcnt_code: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (cnt_cap == '0 || cnt_cap > cfg_per_set)) |-> (done_status == 2'd2));

   a_r7_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
      inval |=> (slot_map == '0));

   a_r8_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cfg_sets != '0) |-> (int'(lat) <= int'(cfg_sets)));

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind cmdslot_alloc cmdslot_alloc_chk #(.MAX_SETS(MAX_SETS), .MAX_CPS(MAX_CPS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_per_set (cfg_per_set),
   .cfg_sets    (cfg_sets),
   .inval       (inval),
   .req_valid   (req_valid),
   .req_count   (req_count),
   .req_ready   (req_ready),
   .done        (done),
   .done_status (done_status),
   .done_cmd    (done_cmd),
   .slot_map    (slot_map)
);

// File: tb/cmdslot_alloc_tb.sv
module cmdslot_alloc_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [4:0]   cfg_per_set = 5'd4;
   logic [3:0]   cfg_sets = 4'd4;
   logic [2:0]   cfg_base = 3'd2;
   logic         inval = 1'b0;
   logic         req_valid = 1'b0;
   logic [4:0]   req_count = '0;
   logic         req_ready;
   logic         done;
   logic [1:0]   done_status;
   logic [3:0]   done_set;
   logic [3:0]   done_cmd;
   logic [127:0] slot_map;

   logic [127:0] exp_map = '0;
   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   cmdslot_alloc u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_per_set(cfg_per_set), .cfg_sets(cfg_sets),
      .cfg_base(cfg_base), .inval(inval), .req_valid(req_valid), .req_count(req_count),
      .req_ready(req_ready), .done(done), .done_status(done_status),
      .done_set(done_set), .done_cmd(done_cmd), .slot_map(slot_map)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic chk_map(input string rq);
      n_chk++;
      if (slot_map !== exp_map) begin
         n_bad++;
         $display("FAIL %s: actual map %h expected %h", rq, slot_map, exp_map);
      end
   endtask

   // origin-restart search: first free run from the origin, restart a set later if it straddles
   function automatic int model_find(input int n, input int per, input int sets);
      int origin = 0;
      int total = per * sets;
      forever begin
         int slot = 128;
         for (int s = origin; s + n <= 128; s++) begin
            bit free = 1'b1;
            for (int k = 0; k < n; k++) if (exp_map[s + k]) free = 1'b0;
            if (free) begin slot = s; break; end
         end
         if (slot >= total) return -1;
         origin += per;
         if (slot + n - 1 < origin) return slot;
      end
   endfunction

   task automatic do_req(input int n, input bit kill, input bit noise, input string rq);
      int per = int'(cfg_per_set);
      int sets = int'(cfg_sets);
      int start = -1;
      int e_stat, e_lat, lat;
      if (n == 0 || n > per) begin
         e_stat = 2; e_lat = 1;
      end else begin
         start = model_find(n, per, sets);
         if (start < 0) begin e_stat = 1; e_lat = sets; end
         else begin e_stat = 0; e_lat = start / per + 1; end
      end
      @(negedge clk);
      req_valid = 1'b1;
      req_count = 5'(n);
      @(negedge clk);
      req_valid = 1'b0;
      inval = kill;
      lat = 0;
      forever begin
         @(negedge clk);
         inval = 1'b0;
         req_valid = 1'b0;
         lat++;
         if (done || lat > 20) break;
         if (noise && lat == 1) begin
            req_valid = 1'b1;
            req_count = 5'd1;
         end
      end
      chk(done === 1'b1, {rq, " R8 done seen"}, int'(done), 1);
      chk(lat == e_lat, {rq, " R8 latency"}, lat, e_lat);
      chk(int'(done_status) == e_stat, {rq, " R5/R6 status"}, int'(done_status), e_stat);
      if (e_stat == 0) begin
         chk(int'(done_set) == start / per + int'(cfg_base), {rq, " R2 set"}, int'(done_set),
             start / per + int'(cfg_base));
         chk(int'(done_cmd) == start % per, {rq, " R2 cmd"}, int'(done_cmd), start % per);
         for (int k = 0; k < n; k++) exp_map[start + k] = 1'b1;
      end
      if (kill) exp_map = '0;
      chk_map({rq, " R4 map"});
      @(negedge clk);
      chk(done === 1'b0, {rq, " R8 pulse"}, int'(done), 0);
   endtask

   task automatic do_inval();
      @(negedge clk);
      inval = 1'b1;
      @(negedge clk);
      inval = 1'b0;
      exp_map = '0;
      chk_map("R7 invalidate");
   endtask

   initial begin
      void'($urandom(32'h5A17C0DE));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1, "R1 ready", int'(req_ready), 1);
      chk(done === 1'b0, "R1 done", int'(done), 0);
      chk_map("R1 map");

      // 4 per set, 4 sets, base 2
      do_req(3, 0, 0, "R2 first");          // slots 0..2, set 2 cmd 0
      do_req(2, 0, 0, "R3 straddle");       // run at 3 crosses, goes to 4
      do_req(1, 0, 1, "R2 gap fill");       // slot 3
      do_req(0, 0, 0, "R6 zero");
      do_req(5, 0, 0, "R6 oversize");
      do_req(4, 0, 1, "R3 whole set");      // set 3 partly used, goes to slot 8
      do_req(4, 0, 0, "R2 last set");       // slot 12
      do_req(3, 0, 0, "R5 no room");
      do_req(2, 0, 0, "R2 tail of set 1");  // slot 6
      do_req(1, 0, 0, "R5 full");
      do_inval();
      do_req(2, 1, 0, "R7 inval on commit");

      // R9 random under several geometries
      for (int g = 0; g < 6; g++) begin
         do_inval();
         @(negedge clk);
         cfg_per_set = (g == 0) ? 5'd16 : (g == 1) ? 5'd1 : 5'(1 + $urandom_range(15));
         cfg_sets    = (g == 0) ? 4'd8 : 4'(1 + $urandom_range(7));
         cfg_base    = 3'($urandom_range(7));
         for (int r = 0; r < 50; r++) begin
            int n = $urandom_range(int'(cfg_per_set) + 1);
            if ($urandom_range(19) == 0) do_inval();
            do_req(n, 0, ($urandom_range(1) == 1), "R9 random");
         end
      end
      finished = 1'b1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (150000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule